// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable, cycle-level model of a synchronous burst SRAM with flow-through reads and a common data bus. All control, address and write-data inputs take effect at the rising clock edge. Read data for the address registered at an edge comes straight out of the array in the same cycle, with no output register. The array has two 9-bit byte lanes, and its depth is set by the address width parameter.

There are two ways to start an access. A processor strobe always starts with a read. A controller strobe can write in its own first cycle. After the start, a burst walks through a 2-bit wrap-around group of four addresses, in either linear or interleaved order, under an advance input. The tri-state bus is modelled as separate input data, output data and output-enable signals. The output enable input acts asynchronously on the output-enable signal.

Top module: `ft_burst_sram`

## Requirements
- R1: The chip counts as selected at an edge only when `ce1N`=0, `ce2`=1 and `ce3N`=0. A recognised strobe seen while the chip is not selected ends any burst. `dqOe` is then 0 until a strobe arrives while the chip is selected.
- R2: When `adspN` and `adscN` are both low and `ce1N` is low, only the processor strobe counts. The cycle is a read and nothing is written.
- R3: `adspN` has no effect while `ce1N`=1. The cycle then behaves as a controller-strobe cycle if `adscN`=0. Otherwise it is a burst continuation cycle.
- R4: A selected processor-strobe cycle loads the address and reads, whatever `gwN`, `bweN` and `bwN` are. A write can take place on the continuation cycles that follow.
- R5: A selected controller-strobe cycle loads the address. If the write inputs decode as a write, it writes `dqIn` at that address on the same edge.
- R6: Write decode works as follows. `gwN`=0 writes both lanes. Otherwise, `bweN`=0 writes lane A (bits 8:0) when `bwN[0]`=0 and lane B (bits 17:9) when `bwN[1]`=0. Every other combination is a read.
- R7: On a continuation cycle (no strobe recognised, burst active), `advN`=0 steps the burst counter and `advN`=1 keeps the current address, for both reads and writes. The upper address bits never change during a burst, and the low two bits wrap after four steps. The low two bits are base+n mod 4 when `ilvMode`=0, and base XOR n when `ilvMode`=1.
- R8: `dqOe` is 0 when the chip is deselected, when `oeN`=1, or in the cycle after a write edge. Otherwise it is 1 after a read edge. `dqOut` then shows the word at the address registered at the last edge, in that same cycle.
- R9: After a write, `dqOe` stays 0 through continuation cycles that neither advance nor write. It returns to 1 only after a read strobe or an advancing read.
- R10: Reset (`rstN`=0) leaves the bus undriven and the block idle. Continuation cycles then neither write nor drive until a selected strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, loaded on a selected strobe |
| ce1N | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| adspN | input | 1 | Processor address strobe, active low |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte write enable, active low |
| bwN | input | 2 | Byte selects, active low; bit 0 lane A, bit 1 lane B |
| oeN | input | 1 | Asynchronous output enable, active low |
| ilvMode | input | 1 | Burst order: 1 interleaved, 0 linear |
| dqIn | input | 18 | Write data from the bus |
| dqOut | output | 18 | Read data to the bus |
| dqOe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with `ADDR_W`=8, which gives 256 words. At that size the whole array can be preloaded through controller-strobe writes, so the reference model knows every word. Random addresses can then be read without unknown values. With eight address bits, the bursts can start at every low-bit offset in both orders and wrap inside a group while the upper six bits stay fixed. The long random phase can also reach every strobe, select and write-select combination against an array the model shadows exactly.

// File: rtl/ft_sram_pkg.sv
`timescale 1ns/1ps
package ft_sram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic             load;
    logic             adv;
    logic [LANES-1:0] wrLane;
  } ctlStrobe_t;
endpackage

// File: rtl/ft_burst_ctrl.sv
`timescale 1ns/1ps
module ft_burst_ctrl
  import ft_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             oeN,
  output ctlStrobe_t       ctl,
  output logic             dqOe
);
  logic sel, pStart, cStart, startAny, cont;
  logic activeQ, driveQ;
  logic [LANES-1:0] wrReq;

  always_comb begin
    sel      = !ce1N && ce2 && !ce3N;
    pStart   = !adspN && !ce1N;
    cStart   = !pStart && !adscN;
    startAny = pStart || cStart;
    cont     = !startAny && activeQ;
    if (!gwN)       wrReq = '1;
    else if (!bweN) wrReq = ~bwN;
    else            wrReq = '0;
    ctl.load   = startAny && sel;
    ctl.adv    = cont && !advN;
    ctl.wrLane = ((cStart && sel) || cont) ? wrReq : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      driveQ  <= 1'b0;
    end else begin
      if (startAny) activeQ <= sel;
      if (startAny && !sel)          driveQ <= 1'b0;
      else if (|ctl.wrLane)          driveQ <= 1'b0;
      else if (ctl.load || ctl.adv)  driveQ <= 1'b1;
    end
  end

  assign dqOe = driveQ && !oeN;

  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (startAny && !sel) |=> !dqOe);
  p_proc_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && !adscN && sel) |=> (dqOe == !oeN));
  p_proc_reads_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pStart && sel) |=> (dqOe == !oeN));
  p_write_hiz_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|ctl.wrLane) |=> !dqOe);
  p_hold_hiz_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cont && advN && ctl.wrLane == '0 && !driveQ) |=> !dqOe);
endmodule

// File: rtl/ft_burst_dpath.sv
`timescale 1ns/1ps
module ft_burst_dpath
  import ft_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ilvMode,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] baseQ, baseD, curAddr, effAddr;
  logic [1:0] cntQ, cntD;

  function automatic logic [1:0] burstLow(input logic [1:0] b, input logic [1:0] n,
                                          input logic ilv);
    return ilv ? (b ^ n) : (b + n);
  endfunction

  always_comb begin
    baseD   = ctl.load ? addr : baseQ;
    cntD    = ctl.load ? 2'd0 : (ctl.adv ? cntQ + 2'd1 : cntQ);
    effAddr = {baseD[ADDR_W-1:2], burstLow(baseD[1:0], cntD, ilvMode)};
    curAddr = {baseQ[ADDR_W-1:2], burstLow(baseQ[1:0], cntQ, ilvMode)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
    end else begin
      baseQ <= baseD;
      cntQ  <= cntD;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (ctl.wrLane[g]) laneMem[effAddr] <= dqIn[g*LANE_W +: LANE_W];
    end
    assign dqOut[g*LANE_W +: LANE_W] = laneMem[curAddr];
  end

  p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.adv) |=> $stable(curAddr));
  p_wrap_group_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.adv |=> (curAddr[ADDR_W-1:2] == $past(curAddr[ADDR_W-1:2])));
endmodule

// File: rtl/ft_burst_sram.sv
`timescale 1ns/1ps
module ft_burst_sram
  import ft_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [1:0]        bwN,
  input  logic              oeN,
  input  logic              ilvMode,
  input  logic [17:0]       dqIn,
  output logic [17:0]       dqOut,
  output logic              dqOe
);
  ctlStrobe_t ctl;

  ft_burst_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .oeN(oeN), .ctl(ctl), .dqOe(dqOe)
  );

  ft_burst_dpath #(.ADDR_W(ADDR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .addr(addr), .ilvMode(ilvMode), .ctl(ctl),
    .dqIn(dqIn), .dqOut(dqOut)
  );
endmodule

// File: tb/test_ft_burst_sram.sv
`timescale 1ns/1ps
module test_ft_burst_sram;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce1N = 1, ce2 = 0, ce3N = 1, adspN = 1, adscN = 1, advN = 1;
  logic gwN = 1, bweN = 1, oeN = 0, ilvMode = 0;
  logic [1:0] bwN = 2'b11;
  logic [17:0] dqIn = '0, dqOut;
  logic dqOe;

  int total = 0, bad = 0;
  bit done = 0;

  logic [17:0] refMem [DEPTH];
  int rBase = 0, rCnt = 0;
  bit rAct = 0, rDrv = 0;

  always #2.5 clk = ~clk;

  ft_burst_sram #(.ADDR_W(AW)) i_ft_burst_sram (
    .clk(clk), .rstN(rstN), .addr(addr), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .oeN(oeN), .ilvMode(ilvMode), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  function automatic int refAddr();
    int lo;
    if (ilvMode) lo = (rBase & 3) ^ rCnt;
    else         lo = ((rBase & 3) + rCnt) & 3;
    return (rBase & ~3) | lo;
  endfunction

  task automatic compare(string tag);
    bit expOe;
    expOe = rDrv && !oeN;
    total++;
    if (dqOe !== expOe) begin
      bad++;
      $display("FAIL %s dqOe actual=%0b expected=%0b", tag, dqOe, expOe);
    end
    if (expOe) begin
      total++;
      if (dqOut !== refMem[refAddr()]) begin
        bad++;
        $display("FAIL %s dqOut actual=%h expected=%h", tag, dqOut, refMem[refAddr()]);
      end
    end
  endtask

  task automatic modelEdge();
    bit sel, pS, cS, st;
    bit [1:0] wl, doWr;
    int a;
    sel = !ce1N && ce2 && !ce3N;
    pS = !adspN && !ce1N;
    cS = !pS && !adscN;
    st = pS || cS;
    wl = !gwN ? 2'b11 : (!bweN ? ~bwN : 2'b00);
    doWr = 2'b00;
    if (st && sel) begin
      rBase = int'(addr); rCnt = 0; rAct = 1;
      doWr = cS ? wl : 2'b00;
      rDrv = (doWr == 0);
    end else if (st) begin
      rAct = 0; rDrv = 0;
    end else if (rAct) begin
      if (!advN) rCnt = (rCnt + 1) & 3;
      doWr = wl;
      if (doWr != 0) rDrv = 0;
      else if (!advN) rDrv = 1;
    end
    a = refAddr();
    if (doWr[0]) refMem[a][8:0]  = dqIn[8:0];
    if (doWr[1]) refMem[a][17:9] = dqIn[17:9];
  endtask

  task automatic cyc(string tag, int a, bit c1n, bit c2, bit c3n, bit spn, bit scn,
                     bit avn, bit gwn, bit bwen, bit [1:0] bwn, bit oen, int d);
    @(negedge clk);
    addr = AW'(a); ce1N = c1n; ce2 = c2; ce3N = c3n; adspN = spn; adscN = scn;
    advN = avn; gwN = gwn; bweN = bwen; bwN = bwn; oeN = oen; dqIn = 18'(d);
    @(posedge clk);
    modelEdge();
    #1;
    compare(tag);
  endtask

  // shorthands: selected controller strobe, selected processor strobe, continuation
  task automatic cRd(string tag, int a);
    cyc(tag, a, 0, 1, 0, 1, 0, 1, 1, 1, 2'b11, 0, 0);
  endtask
  task automatic cont(string tag, bit avn, bit gwn, bit bwen, bit [1:0] bwn, int d);
    cyc(tag, 0, 1, 0, 1, 1, 1, avn, gwn, bwen, bwn, 0, d);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; adspN = 1; adscN = 1; oeN = 0;
    rAct = 0; rDrv = 0; rBase = 0; rCnt = 0;
    #1;
    total++;
    if (dqOe !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset dqOe actual=%0b expected=0", dqOe);
    end
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    doReset();
    // R10: idle after reset, continuation cannot write or drive
    cont("R10", 0, 0, 1, 2'b11, 18'h3ffff);
    cont("R10", 1, 1, 1, 2'b11, 0);

    // preload every word with controller-strobe global writes (R5, R8 bus off)
    for (int i = 0; i < DEPTH; i++)
      cyc("R5", i, 0, 1, 0, 1, 0, 1, 0, 1, 2'b11, 0, (i * 1237 + 5) & 18'h3ffff);
    doReset();
    cont("R10", 0, 0, 1, 2'b11, 18'h15555);
    cRd("R10", 0);

    // R7 linear burst from offset 2 with wrap
    ilvMode = 0;
    cRd("R7", 8'h0a);
    for (int k = 0; k < 4; k++) cont("R7", 0, 1, 1, 2'b11, 0);
    cont("R7", 1, 1, 1, 2'b11, 0);
    // R7 interleaved burst from offset 1
    ilvMode = 1;
    cRd("R7", 8'h25);
    for (int k = 0; k < 4; k++) cont("R7", 0, 1, 1, 2'b11, 0);
    ilvMode = 0;

    // R4 processor strobe with write inputs active is a read
    cyc("R4", 8'h30, 0, 1, 0, 0, 1, 1, 0, 0, 2'b00, 0, 18'h2aaaa);
    cont("R4", 1, 0, 1, 2'b11, 18'h12345);
    cont("R9", 1, 1, 1, 2'b11, 0);
    cont("R9", 1, 1, 1, 2'b11, 0);
    cont("R9", 0, 1, 1, 2'b11, 0);
    cRd("R4", 8'h30);

    // R6 byte write decode
    cyc("R6", 8'h40, 0, 1, 0, 1, 0, 1, 1, 0, 2'b10, 0, 18'h3ffff);
    cyc("R6", 8'h41, 0, 1, 0, 1, 0, 1, 1, 0, 2'b01, 0, 18'h3ffff);
    cyc("R6", 8'h42, 0, 1, 0, 1, 0, 1, 1, 1, 2'b00, 0, 18'h3ffff);
    cyc("R6", 8'h43, 0, 1, 0, 1, 0, 1, 0, 1, 2'b11, 0, 18'h00000);
    cyc("R6", 8'h44, 0, 1, 0, 1, 0, 1, 1, 0, 2'b11, 0, 18'h3ffff);
    for (int k = 0; k < 5; k++) cRd("R6", 8'h40 + k);

    // R2 both strobes: processor wins, no write
    cyc("R2", 8'h50, 0, 1, 0, 0, 0, 1, 0, 0, 2'b00, 0, 18'h0f0f0);
    cRd("R2", 8'h50);

    // R3 processor strobe ignored when ce1N high
    cRd("R3", 8'h60);
    cyc("R3", 8'h70, 1, 1, 0, 0, 1, 1, 1, 1, 2'b11, 0, 0);
    cyc("R3", 8'h70, 1, 1, 0, 0, 1, 0, 1, 1, 2'b11, 0, 0);
    cyc("R3", 8'h70, 1, 1, 0, 0, 0, 1, 1, 1, 2'b11, 0, 0);
    cont("R3", 0, 0, 1, 2'b11, 18'h3ffff);
    cRd("R3", 8'h70);

    // R1 deselect through each enable
    cyc("R1", 8'h11, 0, 0, 0, 1, 0, 1, 1, 1, 2'b11, 0, 0);
    cRd("R1", 8'h12);
    cyc("R1", 8'h13, 0, 1, 1, 1, 0, 1, 1, 1, 2'b11, 0, 0);
    cRd("R1", 8'h14);
    cyc("R1", 8'h15, 0, 0, 0, 0, 1, 1, 0, 1, 2'b11, 0, 18'h3ffff);
    cont("R1", 0, 0, 1, 2'b11, 18'h3ffff);
    cRd("R1", 8'h15);

    // R8 output enable high keeps bus off during a read
    cyc("R8", 8'h20, 0, 1, 0, 1, 0, 1, 1, 1, 2'b11, 1, 0);
    cyc("R8", 8'h20, 0, 1, 0, 1, 1, 0, 1, 1, 2'b11, 0, 0);

    // random traffic against the model (R8 and all decode paths)
    for (int k = 0; k < 3000; k++) begin
      ilvMode = (k / 500) % 2;
      cyc("R8", $urandom % DEPTH,
          ($urandom % 6) == 0, ($urandom % 6) != 0, ($urandom % 6) == 0,
          ($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 2) == 0,
          ($urandom % 4) != 0, ($urandom % 2) == 0, 2'($urandom),
          ($urandom % 5) == 0, 18'($urandom));
    end
    summary();
  end
endmodule